// File: doc/BRIEF.md
# Burst-Capable Synchronous SRAM Front End

This block models the synchronous front end of a flow-through SRAM with a word split into byte lanes. Two active-low address strobes can load a new address: one driven by a processor and one by a memory controller. Three chip selects decide whether the loaded access targets this device. The two low address bits seed a burst counter. An advance input steps the counter through the aligned four-word block, and the upper address bits stay fixed.

Writes happen on the clock edge where the write controls are sampled. A global write stores every lane. A byte write stores only the lanes whose select is low. Read data flows from a small internal array, addressed by the state registered at the previous edge. The pad is split into separate data-in, data-out and drive-enable ports. Output drive is gated by an active-low output enable and is held off for the first cycle after the device leaves the deselected state. A sleep input freezes all state and blocks writes.

Top module: `sync_sram_fe`

## Requirements
- R1: A clock edge with a recognised strobe captures `addr_i` into the address register. The same edge loads `addr_i[1:0]` into the burst counter. After that edge `rdata_o` shows the word at the captured address.
- R2: The processor strobe `strobe_cpu_ni` is ignored while `sel1_ni` is high. In that case the address register keeps its value and the selection state is unchanged. The controller strobe `strobe_ctl_ni` still loads while `sel1_ni` is high, and that load deselects the device.
- R3: A load selects the device only when `sel1_ni` is low, `sel2_i` is high and `sel3_ni` is low. The chip selects are sampled only on load edges, so a change in them on any other edge has no effect.
- R4: An edge with `adv_ni` low and no load, while the device is selected, adds one to the burst counter. The counter wraps from 3 to 0, and the upper address bits stay fixed.
- R5: When `gwr_ni` is low on a write edge, all lanes are written, whatever `bwr_ni` and `lane_ni` are.
- R6: When `gwr_ni` is high and `bwr_ni` is low, lane i (`wdata_i` bits 8i+7..8i) is written only if `lane_ni[i]` is low. When `bwr_ni` and `gwr_ni` are both high, nothing is written.
- R7: A write goes to the address effective at that edge. On a load edge this is `addr_i`; on other edges it is the registered address with the counter bits. No write happens on an edge where the effective selection is off.
- R8: `drive_o` is high only when `oe_ni` is low and the device is selected. It stays low during the first cycle after a load that selects the device from the deselected state. After a load that finds the device already selected, it is high at once.
- R9: While `sleep_i` is high, no register or array word changes and `drive_o` is low. After sleep ends, the held address and data are seen again.
- R10: Reset leaves the device deselected with `drive_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| strobe_cpu_ni | input | 1 | Processor address strobe, active low |
| strobe_ctl_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| sel1_ni | input | 1 | Chip select 1, active low, also gates the processor strobe |
| sel2_i | input | 1 | Chip select 2, active high |
| sel3_ni | input | 1 | Chip select 3, active low |
| gwr_ni | input | 1 | Global write, active low |
| bwr_ni | input | 1 | Byte write enable, active low |
| lane_ni | input | LANES | Per-lane byte select, active low |
| oe_ni | input | 1 | Output enable, active low |
| sleep_i | input | 1 | Sleep, freezes state |
| wdata_i | input | LANES*LANE_W | Write data from the pad |
| rdata_o | output | LANES*LANE_W | Read data to the pad |
| drive_o | output | 1 | Pad drive enable |

## Verification
A wrong burst counter or address register shows up on `rdata_o` in the very cycle after the edge that corrupted it, because the read path is flow-through. A lost or stale selection bit shows on `drive_o` in the same cycle, provided the output enable is low. A bad lane enable or a write while deselected stays hidden in the array. It shows only when that word is read back, which the directed scenarios do right after each write. Sleep-hold faults appear when the frozen address is read again after sleep ends.

// File: rtl/sync_sram_fe_pkg.sv
package sync_sram_fe_pkg;
  localparam int unsigned CNT_W = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_CTL  = 2'd2
  } load_src_e;
endpackage

// File: rtl/sync_sram_fe_addr.sv
module sync_sram_fe_addr
  import sync_sram_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_ni,
  input  logic              ctl_ni,
  input  logic              adv_ni,
  input  logic              sel1_ni,
  input  logic              sel2_i,
  input  logic              sel3_ni,
  output logic              eff_sel_o,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sel_o,
  output logic              mask_o
);
  localparam int unsigned BLK_W = ADDR_W - CNT_W;

  load_src_e        src;
  logic             load;
  logic             new_sel;
  logic [BLK_W-1:0] blk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;
  logic             mask_q;

  // processor strobe wins, but only when select 1 lets it through
  always_comb begin
    if (!cpu_ni && !sel1_ni)  src = SRC_CPU;
    else if (!ctl_ni)         src = SRC_CTL;
    else                      src = SRC_NONE;
  end

  assign load       = (src != SRC_NONE);
  assign new_sel    = !sel1_ni && sel2_i && !sel3_ni;
  assign rd_addr_o  = {blk_q, cnt_q};
  assign eff_addr_o = load ? addr_i : rd_addr_o;
  assign eff_sel_o  = load ? new_sel : sel_q;
  assign sel_o      = sel_q;
  assign mask_o     = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q  <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      mask_q <= 1'b0;
    end else if (!hold_i) begin
      if (load) begin
        blk_q  <= addr_i[ADDR_W-1:CNT_W];
        cnt_q  <= addr_i[CNT_W-1:0];
        sel_q  <= new_sel;
        mask_q <= new_sel && !sel_q;
      end else begin
        mask_q <= 1'b0;
        if (sel_q && !adv_ni) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  p_load_cnt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !ctl_ni) |=> (cnt_q == $past(addr_i[CNT_W-1:0])));

  p_cpu_veto_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !cpu_ni && sel1_ni && ctl_ni) |=> ($stable(blk_q) && $stable(sel_q)));

  p_adv_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && cpu_ni && ctl_ni && sel_q && !adv_ni)
      |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) && $stable(blk_q));

  p_sleep_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(blk_q) && $stable(cnt_q) && $stable(sel_q)));
endmodule

// File: rtl/sync_sram_fe_wen.sv
module sync_sram_fe_wen #(
  parameter int unsigned LANES = 4
) (
  input  logic             en_i,
  input  logic             gwr_ni,
  input  logic             bwr_ni,
  input  logic [LANES-1:0] lane_ni,
  output logic [LANES-1:0] wen_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wen_o[i] = en_i && (!gwr_ni || (!bwr_ni && !lane_ni[i]));
  end

  always_comb begin
    if (en_i && !gwr_ni) begin
      p_global_all_r5: assert (&wen_o);
    end
    if (!en_i) begin
      p_no_write_off_r7: assert (wen_o == '0);
    end
  end
endmodule

// File: rtl/sync_sram_fe_array.sv
module sync_sram_fe_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        wen_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wen_i[i]) mem_q[waddr_i] <= wdata_i[i*LANE_W +: LANE_W];
    end

    assign rdata_o[i*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/sync_sram_fe.sv
module sync_sram_fe #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    strobe_cpu_ni,
  input  logic                    strobe_ctl_ni,
  input  logic                    adv_ni,
  input  logic                    sel1_ni,
  input  logic                    sel2_i,
  input  logic                    sel3_ni,
  input  logic                    gwr_ni,
  input  logic                    bwr_ni,
  input  logic [LANES-1:0]        lane_ni,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);
  logic              eff_sel;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic              sel_q;
  logic              mask_q;
  logic [LANES-1:0]  wen;

  sync_sram_fe_addr #(.ADDR_W(ADDR_W)) i_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (sleep_i),
    .addr_i     (addr_i),
    .cpu_ni     (strobe_cpu_ni),
    .ctl_ni     (strobe_ctl_ni),
    .adv_ni     (adv_ni),
    .sel1_ni    (sel1_ni),
    .sel2_i     (sel2_i),
    .sel3_ni    (sel3_ni),
    .eff_sel_o  (eff_sel),
    .eff_addr_o (eff_addr),
    .rd_addr_o  (rd_addr),
    .sel_o      (sel_q),
    .mask_o     (mask_q)
  );

  sync_sram_fe_wen #(.LANES(LANES)) i_wen (
    .en_i    (eff_sel && !sleep_i),
    .gwr_ni  (gwr_ni),
    .bwr_ni  (bwr_ni),
    .lane_ni (lane_ni),
    .wen_o   (wen)
  );

  sync_sram_fe_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk_i   (clk_i),
    .wen_i   (wen),
    .waddr_i (eff_addr),
    .wdata_i (wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (rdata_o)
  );

  assign drive_o = !oe_ni && sel_q && !mask_q && !sleep_i;

  p_mask_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && !$past(sel_q)) |-> !drive_o);

  p_drive_needs_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> sel_q);
endmodule

// File: tb/test_sync_sram_fe.sv
`timescale 1ns/1ps
module test_sync_sram_fe;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
  logic          s1_n = 1'b0, s2 = 1'b1, s3_n = 1'b0;
  logic          gwr_n = 1'b1, bwr_n = 1'b1;
  logic [3:0]    lane_n = 4'hf;
  logic          oe_n = 1'b0, sleep = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          drive;

  int runs = 0, fails = 0;
  bit done = 0;
  logic [31:0] mdl [64];

  sync_sram_fe i_sync_sram_fe (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .strobe_cpu_ni(cpu_n), .strobe_ctl_ni(ctl_n), .adv_ni(adv_n),
    .sel1_ni(s1_n), .sel2_i(s2), .sel3_ni(s3_n),
    .gwr_ni(gwr_n), .bwr_ni(bwr_n), .lane_ni(lane_n),
    .oe_ni(oe_n), .sleep_i(sleep), .wdata_i(wdata),
    .rdata_o(rdata), .drive_o(drive)
  );

  always #4 clk = ~clk;

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic idle;
    cpu_n = 1'b1; ctl_n = 1'b1; adv_n = 1'b1;
    s1_n = 1'b0; s2 = 1'b1; s3_n = 1'b0;
    gwr_n = 1'b1; bwr_n = 1'b1; lane_n = 4'hf;
    oe_n = 1'b0; sleep = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // controller-strobe load with global write
  task automatic load_write(input logic [AW-1:0] a, input logic [31:0] d);
    idle(); addr = a; ctl_n = 1'b0; gwr_n = 1'b0; wdata = d;
    tick();
    mdl[a] = d;
    idle();
  endtask

  task automatic t_reset;
    chk("R10 drive after reset", {31'd0, drive}, 32'd0);
  endtask

  task automatic t_first_write;
    load_write(6'h10, 32'h1122_3344);
    chk("R8 masked first cycle", {31'd0, drive}, 32'd0);
    chk("R1 data at loaded addr", rdata, 32'h1122_3344);
    tick();
    chk("R8 drive after mask", {31'd0, drive}, 32'd1);
  endtask

  task automatic t_byte_write;
    bwr_n = 1'b0; lane_n = 4'b1010; wdata = 32'hAABB_CCDD;
    tick();
    mdl[6'h10] = 32'h11BB_33DD;
    idle();
    chk("R6 lanes 0 and 2", rdata, mdl[6'h10]);
    bwr_n = 1'b1; lane_n = 4'h0; wdata = 32'hFFFF_FFFF;
    tick();
    idle();
    chk("R6 no write without bwr", rdata, mdl[6'h10]);
  endtask

  task automatic t_global;
    gwr_n = 1'b0; bwr_n = 1'b1; lane_n = 4'hf; wdata = 32'h5A5A_0F0F;
    tick();
    mdl[6'h10] = 32'h5A5A_0F0F;
    idle();
    chk("R5 global write all lanes", rdata, mdl[6'h10]);
  endtask

  task automatic t_burst;
    for (int i = 0; i < 4; i++) load_write(6'h20 + AW'(i), 32'hB000_0000 + i);
    addr = 6'h22; cpu_n = 1'b0;
    tick();
    idle();
    chk("R1 cpu load addr", rdata, mdl[6'h22]);
    chk("R8 no mask when selected", {31'd0, drive}, 32'd1);
    adv_n = 1'b0;
    tick();
    chk("R4 advance to 3", rdata, mdl[6'h23]);
    tick();
    chk("R4 wrap to 0", rdata, mdl[6'h20]);
    tick();
    chk("R4 then 1", rdata, mdl[6'h21]);
    idle();
  endtask

  task automatic t_veto;
    cpu_n = 1'b0; s1_n = 1'b1; addr = 6'h10;
    tick();
    idle();
    chk("R2 cpu ignored data", rdata, mdl[6'h21]);
    chk("R2 cpu ignored drive", {31'd0, drive}, 32'd1);
    cpu_n = 1'b0; ctl_n = 1'b0; s1_n = 1'b1; addr = 6'h10;
    tick();
    idle();
    chk("R2 ctl loads deselect", {31'd0, drive}, 32'd0);
  endtask

  task automatic t_deselect_write;
    gwr_n = 1'b0; wdata = 32'hDEAD_BEEF;
    tick();
    ctl_n = 1'b0; s2 = 1'b0; addr = 6'h10; gwr_n = 1'b0; wdata = 32'hDEAD_BEEF;
    tick();
    idle();
    ctl_n = 1'b0; addr = 6'h10;
    tick();
    idle();
    chk("R8 mask after reselect", {31'd0, drive}, 32'd0);
    tick();
    chk("R7 no write while deselected", rdata, mdl[6'h10]);
    chk("R3 selected after load", {31'd0, drive}, 32'd1);
  endtask

  task automatic t_select_sampling;
    s2 = 1'b0; s3_n = 1'b1;
    tick();
    chk("R3 selects ignored without load", {31'd0, drive}, 32'd1);
    idle();
  endtask

  task automatic t_sleep;
    sleep = 1'b1; ctl_n = 1'b0; addr = 6'h20; gwr_n = 1'b0; wdata = 32'h0BAD_0BAD;
    tick();
    chk("R9 drive low in sleep", {31'd0, drive}, 32'd0);
    tick();
    idle();
    tick();
    chk("R9 address held", rdata, mdl[6'h10]);
    chk("R9 drive after sleep", {31'd0, drive}, 32'd1);
    ctl_n = 1'b0; addr = 6'h20;
    tick();
    idle();
    chk("R9 no write in sleep", rdata, mdl[6'h20]);
  endtask

  task automatic t_oe;
    oe_n = 1'b1;
    #1;
    chk("R8 oe high", {31'd0, drive}, 32'd0);
    oe_n = 1'b0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_first_write();
    t_byte_write();
    t_global();
    t_burst();
    t_veto();
    t_deselect_write();
    t_select_sampling();
    t_sleep();
    t_oe();
    done = 1;
    summary();
  end
endmodule